// File: doc/BRIEF.md
# External Interrupt Request Controller

This block watches one active-low external interrupt pin and turns its activity into a latched pending request. The pin first passes through a synchronizer. A falling edge on the synchronized signal sets the request latch. In level-sensitive mode, the latch is also set on every cycle in which the pin is held low. A mask bit gates the latch onto the interrupt request line to the CPU. The latch keeps recording events while the mask is set, so a request that arrives during masking is not lost.

Software uses a single 8-bit status/control register, written and read over a simple single-cycle bus. The register holds these fields:
- a sensitivity-mode bit;
- a mask bit;
- a write-one acknowledge bit that clears the latch and always reads back as zero;
- a read-only pending flag;
- a bit that switches off the pin's internal pullup.

The block only drives the pullup enable signal. The pad itself sits outside it.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, `irq_o` is 0 and `pullup_en_o` is 1.
- R2: In edge mode (bit 0 = 0), a high-to-low change of the pin sets the pending flag on the third rising clock edge after the pin changes. This delay comes from two synchronizer flops plus the latch. A pin that is held low does not set the flag again after it has been acknowledged.
- R3: In level mode (bit 0 = 1), the pending flag is set on every cycle in which the synchronized pin is low. An acknowledge issued while the pin is still low leaves the flag set. Once the pin is high, an acknowledge clears the flag for good.
- R4: Writing 1 to bit 2 (acknowledge) clears the pending flag at that write's clock edge. Bit 2 always reads 0.
- R5: If an acknowledge and a new set event fall on the same clock edge, the pending flag stays set.
- R6: Bit 1 is the mask. `irq_o` equals pending AND NOT mask. The pending flag still sets while the mask is 1.
- R7: Bit 3 reads as the pending flag. Only set events and acknowledges change it, and writes to bit 3 have no effect.
- R8: Bit 6 disables the pullup. `pullup_en_o` is the inverse of bit 6.
- R9: Bits 7, 5 and 4 always read 0, and writing them has no effect on any other field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_pin_ni | input | 1 | External interrupt pin, active low, asynchronous |
| reg_we_i | input | 1 | Register write strobe, one cycle per write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Masked interrupt request to the CPU |
| pullup_en_o | output | 1 | Pullup enable control for the pad |

## Verification
On every cycle, assertions check how the latch moves from cycle to cycle:
- a synchronized falling edge sets it;
- a low level in level mode sets it;
- an acknowledge with no competing event clears it;
- otherwise it holds its value.

Three things only the bench scenarios can show: the exact three-edge latency from the pin, the difference between edge and level mode when an acknowledge arrives while the pin is still low, and the register readback of the acknowledge, unimplemented and read-only bits. The bench also shows that a masked request reappears on `irq_o` when the mask is cleared.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned BIT_MODE = 0;
  localparam int unsigned BIT_MASK = 1;
  localparam int unsigned BIT_ACK  = 2;
  localparam int unsigned BIT_PEND = 3;
  localparam int unsigned BIT_PUD  = 6;

  typedef struct packed {
    logic pull_dis;
    logic mask;
    logic mode;
  } irq_ctrl_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[0] <= 1'b1;
          else         stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[i] <= 1'b1;
          else         stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_s_i,
  input  logic level_mode_i,
  input  logic ack_i,
  output logic pend_o
);
  logic prev_q;
  logic pend_q;
  logic fall;
  logic set_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= pin_s_i;
  end

  assign fall    = prev_q & ~pin_s_i;
  assign set_evt = fall | (level_mode_i & ~pin_s_i);

  // set has priority over ack
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (set_evt) pend_q <= 1'b1;
    else if (ack_i)   pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  AST_FALL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pin_s_i) |=> pend_o); // R2

  AST_LEVEL_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_mode_i && !pin_s_i) |=> pend_o); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && pin_s_i && !level_mode_i && !$fell(pin_s_i)) |=> !pend_o); // R4

  AST_PEND_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_i && pin_s_i && !$fell(pin_s_i)) |=> (pend_o == $past(pend_o))); // R7
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             pend_i,
  output irq_ctrl_t        ctrl_o,
  output logic             ack_o,
  output logic [REG_W-1:0] rdata_o
);
  irq_ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q.mode     <= wdata_i[BIT_MODE];
      ctrl_q.mask     <= wdata_i[BIT_MASK];
      ctrl_q.pull_dis <= wdata_i[BIT_PUD];
    end
  end

  assign ack_o = we_i & wdata_i[BIT_ACK];

  always_comb begin
    rdata_o           = '0;
    rdata_o[BIT_MODE] = ctrl_q.mode;
    rdata_o[BIT_MASK] = ctrl_q.mask;
    rdata_o[BIT_PEND] = pend_i;
    rdata_o[BIT_PUD]  = ctrl_q.pull_dis;
  end

  assign ctrl_o = ctrl_q;

  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (ctrl_o.mask == $past(wdata_i[BIT_MASK]))); // R6
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_pin_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o,
  output logic             pullup_en_o
);
  logic      pin_s;
  logic      pend;
  logic      ack;
  irq_ctrl_t ctrl;

  ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (irq_pin_ni),
    .sync_o  (pin_s)
  );

  ext_irq_detect u_detect (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pin_s_i      (pin_s),
    .level_mode_i (ctrl.mode),
    .ack_i        (ack),
    .pend_o       (pend)
  );

  ext_irq_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .pend_i  (pend),
    .ctrl_o  (ctrl),
    .ack_o   (ack),
    .rdata_o (reg_rdata_o)
  );

  assign irq_o       = pend & ~ctrl.mask;
  assign pullup_en_o = ~ctrl.pull_dis;

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> reg_rdata_o[BIT_PEND]); // R6
endmodule

// File: tb/ext_irq_ctrl_test.sv
module ext_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin_n = 1'b1;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic       pu_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] rd;
    logic       irq;
    logic       pu;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  ext_irq_ctrl uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_pin_ni  (pin_n),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq),
    .pullup_en_o (pu_en)
  );

  // monitor: compare queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (rdata !== e.rd || irq !== e.irq || pu_en !== e.pu) begin
          fails++;
          $display("FAIL %s: rdata=%02h irq=%b pu=%b expected rdata=%02h irq=%b pu=%b",
                   e.tag, rdata, irq, pu_en, e.rd, e.irq, e.pu);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1;
    wdata = d;
    @(posedge clk);
    #2;
    we = 1'b0;
    wdata = '0;
  endtask

  task automatic expect_st(input logic [7:0] rd, input logic i, input logic pu, input string tag);
    exp_t e;
    e.rd = rd; e.irq = i; e.pu = pu; e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_st(8'h00, 1'b0, 1'b1, "R1 reset state");

    // R2 edge latency
    pin_n = 1'b0;
    step(2);
    expect_st(8'h00, 1'b0, 1'b1, "R2 not yet pending after two edges");
    step(1);
    expect_st(8'h08, 1'b1, 1'b1, "R2 pending on third edge");

    // R4 ack while pin still low, edge mode
    wr(8'h04);
    expect_st(8'h00, 1'b0, 1'b1, "R4 ack clears pending");
    step(3);
    expect_st(8'h00, 1'b0, 1'b1, "R2 held low does not re-set in edge mode");

    // R6 masking
    pin_n = 1'b1; step(3);
    pin_n = 1'b0; step(3);
    expect_st(8'h08, 1'b1, 1'b1, "R2 second falling edge");
    wr(8'h02);
    expect_st(8'h0A, 1'b0, 1'b1, "R6 mask blocks irq, pending kept");
    wr(8'h00);
    expect_st(8'h08, 1'b1, 1'b1, "R6 unmask releases irq");
    pin_n = 1'b1; step(3);
    wr(8'h04);
    expect_st(8'h00, 1'b0, 1'b1, "R4 ack with pin high");

    // R3 level mode
    wr(8'h01);
    expect_st(8'h01, 1'b0, 1'b1, "R3 level mode selected");
    pin_n = 1'b0; step(3);
    expect_st(8'h09, 1'b1, 1'b1, "R3 pending in level mode");
    wr(8'h05);
    expect_st(8'h09, 1'b1, 1'b1, "R3 ack while low keeps pending");
    step(2);
    expect_st(8'h09, 1'b1, 1'b1, "R3 still pending while low");
    wr(8'h03);
    expect_st(8'h0B, 1'b0, 1'b1, "R6 masked in level mode");
    pin_n = 1'b1; step(3);
    wr(8'h05);
    expect_st(8'h01, 1'b0, 1'b1, "R3 ack after pin high clears");
    step(3);
    expect_st(8'h01, 1'b0, 1'b1, "R3 stays clear with pin high");

    // R5 ack coincides with falling edge
    wr(8'h00);
    pin_n = 1'b0;
    step(2);
    wr(8'h04);
    expect_st(8'h08, 1'b1, 1'b1, "R5 new edge wins over ack");
    pin_n = 1'b1; step(3);
    wr(8'h04);
    expect_st(8'h00, 1'b0, 1'b1, "R4 cleared after R5 case");

    // R9 / R7 unimplemented and read-only bits
    wr(8'hB8);
    expect_st(8'h00, 1'b0, 1'b1, "R9 unimplemented and flag writes ignored");
    pin_n = 1'b0; step(3);
    wr(8'hB0);
    expect_st(8'h08, 1'b1, 1'b1, "R7 writing 0 to flag has no effect");
    pin_n = 1'b1; step(3);
    wr(8'h04);
    expect_st(8'h00, 1'b0, 1'b1, "R4 clear before pullup test");

    // R8 pullup, R4 ack reads 0
    wr(8'h44);
    expect_st(8'h40, 1'b0, 1'b0, "R8 pullup disabled, R4 ack reads 0");
    wr(8'h00);
    expect_st(8'h00, 1'b0, 1'b1, "R8 pullup re-enabled");

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule